// File: doc/BRIEF.md
# Ingress Frame Admission Filter

This block sits on the receive side of one switch port and gives a keep-or-discard decision for every Ethernet frame that arrives. It watches a byte-wide receive stream. The stream marks the first and last byte of each frame and qualifies every byte with a valid strobe. From that stream the block takes the destination address and counts the bytes of the frame. It also keeps a count of broadcast-class frames in a repeating time window.

When the last byte of a frame arrives, the block checks four things. It looks for reserved bridge-group destinations and for frames longer than the selected size limit. It looks for frames too short to carry a full destination address. It also looks for broadcast-class frames that arrive after the per-window allowance is used up. One cycle after the end of the frame it presents a verdict: accept, or drop with exactly one reason flag. The verdict stays on the outputs until the next frame starts.

Static inputs set the behaviour:
- whether the configurable reserved range is filtered;
- which of two length limits applies;
- whether all group-addressed frames or only all-ones frames count toward storm protection;
- which of four frame allowances applies.

Top module: `ingress_admit`

## Requirements
- R1: A beat with rx_valid_i and rx_eof_i high produces verdict_valid_o high with its accept_o and flags from the next cycle. These stay unchanged until a beat with rx_valid_i and rx_sof_i high is taken. Such a start-of-frame beat that is not also an end-of-frame beat clears verdict_valid_o, accept_o and all flags from the next cycle.
- R2: A frame of 6 or more bytes whose destination (first six bytes, first byte most significant) is 01-80-C2-00-00-01 is dropped with drop_rsvd_o, whatever the configuration.
- R3: With cfg_rsvd_filt_i = 1, destinations 01-80-C2-00-00-02 through 01-80-C2-00-00-0F are dropped with drop_rsvd_o. With it 0 they are accepted. 01-80-C2-00-00-00 and 01-80-C2-00-00-10 are never dropped for being reserved.
- R4: Frame length counts every valid byte from the start-of-frame beat through the end-of-frame beat. With cfg_short_limit_i = 1, a frame longer than 1536 bytes is dropped with drop_long_o. With it 0, the limit is 1552 bytes. A frame exactly at the limit is accepted.
- R5: A frame shorter than 6 bytes is dropped with drop_runt_o only. This includes a single-byte frame whose start and end fall on one beat.
- R6: With cfg_mcast_storm_i = 0, only destination FF-FF-FF-FF-FF-FF is broadcast-class. With it 1, any destination whose first byte has bit 0 set is broadcast-class.
- R7: Within one window, broadcast-class frames of 6 or more bytes are counted. Once the count equals the allowance picked by cfg_storm_sel_i (codes 0,1,2,3 give 2,4,8,16 frames by default), further broadcast-class frames are dropped with drop_storm_o.
- R8: The broadcast-class count clears every WINDOW_CYC clock cycles, so broadcast-class frames are accepted again in a later window.
- R9: At most one flag is set. Priority is runt, then reserved, then oversize, then storm. accept_o is high exactly when a verdict is valid and no flag is set.
- R10: While rst_ni is low, verdict_valid_o, accept_o and all flags are 0, and the window count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | First byte of frame (with valid) |
| rx_eof_i | input | 1 | Last byte of frame (with valid) |
| rx_data_i | input | 8 | Receive byte |
| cfg_rsvd_filt_i | input | 1 | Filter reserved range 02..0F |
| cfg_short_limit_i | input | 1 | 1: 1536-byte limit, 0: 1552-byte limit |
| cfg_mcast_storm_i | input | 1 | 1: all group addresses count as broadcast-class |
| cfg_storm_sel_i | input | 2 | Storm allowance select |
| verdict_valid_o | output | 1 | Verdict present |
| accept_o | output | 1 | Frame admitted |
| drop_rsvd_o | output | 1 | Dropped: reserved destination |
| drop_long_o | output | 1 | Dropped: oversize |
| drop_storm_o | output | 1 | Dropped: broadcast storm |
| drop_runt_o | output | 1 | Dropped: too short to classify |

## Verification
The bench tests frames one byte either side of each length limit. A design with an off-by-one counter would drop the frame at the limit or admit the one just past it.

It tests the edges of the reserved range (00, 01, 02, 0F, 10) under both filter settings. A wrong range compare would filter the 00 or 10 address or would let 01 through.

It sends one more broadcast-class frame than the allowance in a single window, then waits for a new window. A wrong count would drop one frame early or late, and a count that never clears would keep dropping. Multicast frames are sent in both storm modes to catch a classifier that ignores the mode. A reserved oversize frame and an oversize storm frame show whether the flag priority is wrong.

// File: rtl/admit_pkg.sv
package admit_pkg;
  localparam int DA_BYTES = 6;

  typedef struct packed {
    logic runt;
    logic storm;
    logic oversize;
    logic rsvd;
  } drop_flags_t;
endpackage

// File: rtl/admit_len_cnt.sv
module admit_len_cnt #(
  parameter int LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             sof_i,
  output logic [LEN_W-1:0] idx_o,
  output logic [LEN_W-1:0] len_now_o
);
  localparam logic [LEN_W-1:0] SAT = '1;

  logic [LEN_W-1:0] len_q;

  assign idx_o     = sof_i ? '0 : len_q;
  assign len_now_o = sof_i ? LEN_W'(1) : ((len_q == SAT) ? SAT : len_q + LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (beat_i) len_q <= len_now_o;
  end
endmodule

// File: rtl/admit_da_parse.sv
module admit_da_parse
  import admit_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic [LEN_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic             rsvd_fixed_o,
  output logic             rsvd_range_o,
  output logic             bcast_o,
  output logic             group_o
);
  logic [7:0] da_q   [DA_BYTES];
  logic [7:0] da_now [DA_BYTES];

  // bytes landing this beat are merged so eof on byte 6 classifies correctly
  for (genvar k = 0; k < DA_BYTES; k++) begin : g_byte
    logic hit;
    assign hit       = beat_i && (idx_i == LEN_W'(k));
    assign da_now[k] = hit ? data_i : da_q[k];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  da_q[k] <= '0;
      else if (hit) da_q[k] <= data_i;
    end
  end

  logic [47:0] da;
  assign da = {da_now[0], da_now[1], da_now[2], da_now[3], da_now[4], da_now[5]};

  logic grp_prefix;
  assign grp_prefix   = (da[47:8] == 40'h0180C20000);
  assign rsvd_fixed_o = grp_prefix && (da[7:0] == 8'h01);
  assign rsvd_range_o = grp_prefix && (da[7:0] >= 8'h02) && (da[7:0] <= 8'h0F);
  assign bcast_o      = &da;
  assign group_o      = da[40];
endmodule

// File: rtl/admit_storm.sv
module admit_storm #(
  parameter int WINDOW_CYC = 25_000_000,
  parameter int THR_0      = 2,
  parameter int THR_1      = 4,
  parameter int THR_2      = 8,
  parameter int THR_3      = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       judge_i,
  output logic       over_o
);
  localparam int THR_A   = (THR_0 > THR_1) ? THR_0 : THR_1;
  localparam int THR_B   = (THR_2 > THR_3) ? THR_2 : THR_3;
  localparam int THR_MAX = (THR_A > THR_B) ? THR_A : THR_B;
  localparam int CNT_W   = $clog2(THR_MAX + 1);
  localparam int TICK_W  = $clog2(WINDOW_CYC);

  logic [TICK_W-1:0] tick_q;
  logic [CNT_W-1:0]  cnt_q, cnt_eff, thr;
  logic              wrap;

  assign wrap = (tick_q == TICK_W'(WINDOW_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tick_q <= '0;
    else if (wrap) tick_q <= '0;
    else           tick_q <= tick_q + TICK_W'(1);
  end

  always_comb begin
    unique case (sel_i)
      2'd0:    thr = CNT_W'(THR_0);
      2'd1:    thr = CNT_W'(THR_1);
      2'd2:    thr = CNT_W'(THR_2);
      default: thr = CNT_W'(THR_3);
    endcase
  end

  // a frame ending on the wrap cycle is judged in the fresh window
  assign cnt_eff = wrap ? '0 : cnt_q;
  assign over_o  = (cnt_eff >= thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (judge_i && !over_o) cnt_q <= cnt_eff + CNT_W'(1);
    else if (wrap)               cnt_q <= '0;
  end
endmodule

// File: rtl/ingress_admit.sv
module ingress_admit
  import admit_pkg::*;
#(
  parameter int LIMIT_SHORT = 1536,
  parameter int LIMIT_LONG  = 1552,
  parameter int WINDOW_CYC  = 25_000_000,
  parameter int THR_0       = 2,
  parameter int THR_1       = 4,
  parameter int THR_2       = 8,
  parameter int THR_3       = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic       rx_sof_i,
  input  logic       rx_eof_i,
  input  logic [7:0] rx_data_i,
  input  logic       cfg_rsvd_filt_i,
  input  logic       cfg_short_limit_i,
  input  logic       cfg_mcast_storm_i,
  input  logic [1:0] cfg_storm_sel_i,
  output logic       verdict_valid_o,
  output logic       accept_o,
  output logic       drop_rsvd_o,
  output logic       drop_long_o,
  output logic       drop_storm_o,
  output logic       drop_runt_o
);
  localparam int LEN_MAX = (LIMIT_LONG > LIMIT_SHORT) ? LIMIT_LONG : LIMIT_SHORT;
  localparam int LEN_W   = $clog2(LEN_MAX + 2);

  logic             sof_beat, eof_beat;
  logic [LEN_W-1:0] idx, len_now;
  logic             rsvd_fixed, rsvd_range, is_bcast, is_group;
  logic             bc_class, runt, oversize, judge, over;
  drop_flags_t      flags_d, flags_q;
  logic             valid_q;

  assign sof_beat = rx_valid_i && rx_sof_i;
  assign eof_beat = rx_valid_i && rx_eof_i;

  admit_len_cnt #(.LEN_W(LEN_W)) u_len (
    .clk_i, .rst_ni,
    .beat_i    (rx_valid_i),
    .sof_i     (rx_sof_i),
    .idx_o     (idx),
    .len_now_o (len_now)
  );

  admit_da_parse #(.LEN_W(LEN_W)) u_da (
    .clk_i, .rst_ni,
    .beat_i       (rx_valid_i),
    .idx_i        (idx),
    .data_i       (rx_data_i),
    .rsvd_fixed_o (rsvd_fixed),
    .rsvd_range_o (rsvd_range),
    .bcast_o      (is_bcast),
    .group_o      (is_group)
  );

  assign runt     = (len_now < LEN_W'(DA_BYTES));
  assign oversize = len_now > (cfg_short_limit_i ? LEN_W'(LIMIT_SHORT) : LEN_W'(LIMIT_LONG));
  assign bc_class = cfg_mcast_storm_i ? is_group : is_bcast;
  assign judge    = eof_beat && !runt && bc_class;

  admit_storm #(
    .WINDOW_CYC (WINDOW_CYC),
    .THR_0 (THR_0), .THR_1 (THR_1), .THR_2 (THR_2), .THR_3 (THR_3)
  ) u_storm (
    .clk_i, .rst_ni,
    .sel_i   (cfg_storm_sel_i),
    .judge_i (judge),
    .over_o  (over)
  );

  always_comb begin
    flags_d = '0;
    if (runt)                                        flags_d.runt     = 1'b1;
    else if (rsvd_fixed || (cfg_rsvd_filt_i && rsvd_range)) flags_d.rsvd = 1'b1;
    else if (oversize)                               flags_d.oversize = 1'b1;
    else if (bc_class && over)                       flags_d.storm    = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      flags_q <= '0;
    end else if (eof_beat) begin
      valid_q <= 1'b1;
      flags_q <= flags_d;
    end else if (sof_beat) begin
      valid_q <= 1'b0;
      flags_q <= '0;
    end
  end

  assign verdict_valid_o = valid_q;
  assign accept_o        = valid_q && (flags_q == '0);
  assign drop_rsvd_o     = flags_q.rsvd;
  assign drop_long_o     = flags_q.oversize;
  assign drop_storm_o    = flags_q.storm;
  assign drop_runt_o     = flags_q.runt;
endmodule

// File: rtl/admit_chk.sv
module admit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_valid_i,
  input logic       rx_sof_i,
  input logic       rx_eof_i,
  input logic       verdict_valid_o,
  input logic       accept_o,
  input logic       drop_rsvd_o,
  input logic       drop_long_o,
  input logic       drop_storm_o,
  input logic       drop_runt_o
);
  logic [3:0] fl;
  assign fl = {drop_runt_o, drop_storm_o, drop_long_o, drop_rsvd_o};

  p_flags_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fl));

  p_accept_iff_clean_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> (accept_o == (fl == 4'b0)));

  p_no_flag_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !verdict_valid_o |-> (fl == 4'b0 && !accept_o));

  p_eof_gives_verdict_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_eof_i) |=> verdict_valid_o);

  p_sof_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_sof_i && !rx_eof_i) |=> !verdict_valid_o);

  p_verdict_held_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_valid_o && !(rx_valid_i && (rx_sof_i || rx_eof_i)))
      |=> (verdict_valid_o && $stable(accept_o) && $stable(fl)));
endmodule

bind ingress_admit admit_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .rx_valid_i      (rx_valid_i),
  .rx_sof_i        (rx_sof_i),
  .rx_eof_i        (rx_eof_i),
  .verdict_valid_o (verdict_valid_o),
  .accept_o        (accept_o),
  .drop_rsvd_o     (drop_rsvd_o),
  .drop_long_o     (drop_long_o),
  .drop_storm_o    (drop_storm_o),
  .drop_runt_o     (drop_runt_o)
);

// File: tb/sim_ingress_admit.sv
module sim_ingress_admit;
  localparam int WIN = 300;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = '0;
  logic       cfg_filt = 1'b0, cfg_short = 1'b0, cfg_mc = 1'b0;
  logic [1:0] cfg_sel = 2'd3;
  logic       vv, acc, f_rsvd, f_long, f_storm, f_runt;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  ingress_admit #(.WINDOW_CYC(WIN)) u0 (
    .clk_i (clk), .rst_ni (rst_ni),
    .rx_valid_i (rx_valid), .rx_sof_i (rx_sof), .rx_eof_i (rx_eof), .rx_data_i (rx_data),
    .cfg_rsvd_filt_i (cfg_filt), .cfg_short_limit_i (cfg_short),
    .cfg_mcast_storm_i (cfg_mc), .cfg_storm_sel_i (cfg_sel),
    .verdict_valid_o (vv), .accept_o (acc),
    .drop_rsvd_o (f_rsvd), .drop_long_o (f_long),
    .drop_storm_o (f_storm), .drop_runt_o (f_runt)
  );

  // flags as {runt, storm, long, rsvd}
  typedef struct packed {
    logic [47:0] da;
    logic [15:0] len;
    logic        filt;
    logic        shrt;
    logic [3:0]  exp;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{48'h001122334455, 16'd64,   1'b0, 1'b0, 4'b0000},
    '{48'h0180C2000001, 16'd64,   1'b0, 1'b0, 4'b0001},
    '{48'h0180C2000002, 16'd64,   1'b0, 1'b0, 4'b0000},
    '{48'h0180C2000002, 16'd64,   1'b1, 1'b0, 4'b0001},
    '{48'h0180C200000F, 16'd64,   1'b1, 1'b0, 4'b0001},
    '{48'h0180C2000010, 16'd64,   1'b1, 1'b0, 4'b0000},
    '{48'h0180C2000000, 16'd64,   1'b1, 1'b0, 4'b0000},
    '{48'h001122334455, 16'd1536, 1'b0, 1'b1, 4'b0000},
    '{48'h001122334455, 16'd1537, 1'b0, 1'b1, 4'b0010},
    '{48'h001122334455, 16'd1552, 1'b0, 1'b0, 4'b0000},
    '{48'h001122334455, 16'd1553, 1'b0, 1'b0, 4'b0010},
    '{48'h001122334455, 16'd5,    1'b0, 1'b0, 4'b1000},
    '{48'h001122334455, 16'd6,    1'b0, 1'b0, 4'b0000},
    '{48'h0180C2000001, 16'd2000, 1'b0, 1'b0, 4'b0001},
    '{48'h0180C2000001, 16'd1,    1'b1, 1'b0, 4'b1000},
    '{48'h0180C200000F, 16'd64,   1'b0, 1'b1, 4'b0000}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] da, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = (i == len - 1);
      rx_data  = (i < 6) ? da[47 - 8*i -: 8] : 8'(i);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  function automatic logic [7:0] outv();
    return {2'b00, vv, acc, f_runt, f_storm, f_long, f_rsvd};
  endfunction

  task automatic expect_v(input string req, input logic [3:0] fl);
    chk(req, outv(), {2'b00, 1'b1, (fl == 4'b0), fl});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 in reset", outv(), 8'h00);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 after reset", outv(), 8'h00);

    // R2 R3 R4 R5 R9 table
    cfg_mc = 1'b0; cfg_sel = 2'd3;
    for (int v = 0; v < 16; v++) begin
      cfg_filt  = VEC[v].filt;
      cfg_short = VEC[v].shrt;
      send(VEC[v].da, int'(VEC[v].len));
      expect_v($sformatf("R2/R3/R4/R5/R9 vec %0d", v), VEC[v].exp);
    end

    // R1 hold then clear on next sof
    cfg_filt = 1'b0; cfg_short = 1'b0;
    send(48'h0180C2000001, 8);
    repeat (5) @(negedge clk);
    expect_v("R1 held", 4'b0001);
    @(negedge clk);
    rx_valid = 1'b1; rx_sof = 1'b1; rx_eof = 1'b0; rx_data = 8'h00;
    @(negedge clk);
    rx_sof = 1'b0;
    chk("R1 cleared by sof", outv(), 8'h00);
    for (int i = 1; i < 8; i++) begin
      rx_data = 8'(i + 16); rx_eof = (i == 7);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_eof = 1'b0;
    expect_v("R1 new verdict", 4'b0000);

    // R7 R6 broadcast-only mode, allowance 2
    do_reset();
    cfg_mc = 1'b0; cfg_sel = 2'd0;
    send(48'hFFFFFFFFFFFF, 8); expect_v("R7 bc 1", 4'b0000);
    send(48'hFFFFFFFFFFFF, 8); expect_v("R7 bc 2", 4'b0000);
    send(48'hFFFFFFFFFFFF, 8); expect_v("R7 bc 3 storm", 4'b0100);
    send(48'h01005E000001, 8); expect_v("R6 mcast not counted mode0", 4'b0000);
    send(48'hFFFFFFFFFFFF, 9); expect_v("R7 bc 4 storm", 4'b0100);
    // R8 new window
    repeat (WIN + 10) @(negedge clk);
    send(48'hFFFFFFFFFFFF, 8); expect_v("R8 new window", 4'b0000);

    // R6 R7 group mode, allowance 4
    do_reset();
    cfg_mc = 1'b1; cfg_sel = 2'd1;
    for (int i = 0; i < 4; i++) begin
      send(48'h01005E000001, 10);
      expect_v($sformatf("R6 mcast %0d", i), 4'b0000);
    end
    send(48'h01005E0000FF, 10); expect_v("R7 mcast storm", 4'b0100);
    send(48'hFFFFFFFFFFFF, 1600); expect_v("R9 long over storm", 4'b0010);
    send(48'h001122334455, 10); expect_v("R6 unicast unaffected", 4'b0000);
    send(48'hFFFFFFFFFFFF, 3); expect_v("R5 runt over storm", 4'b1000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule